// File: doc/BRIEF.md
# Memory-Operation Issue Queue

This block is a shared holding station for memory operations waiting to execute. Up to three loads or stores arrive from dispatch each cycle. Each one carries an age stamp, an identifier and three source operands: two address sources and one store-data source, each with a result tag and a ready flag. Result broadcasts from the execution units mark operands ready. Every cycle the queue offers at most one load and at most one store to the memory pipelines.

The queue enforces memory ordering in a simple way. Loads may overtake other loads, but never a store that is older and still waiting. Stores leave strictly in program order. A store departs as soon as its address is computable, and its data may still be outstanding; the store-issue port reports whether the data was already ready. A flush carrying an age boundary discards every entry younger than that boundary, for example after a mispredicted branch.

Top module: `lsq_issue_queue`

## Requirements
- R1: After reset the queue is empty: no load or store is offered, and `disp_ready` is high while no dispatch is presented.
- R2: The queue holds DEPTH (16) entries. `disp_ready` is low exactly when the number of free entries is smaller than the number of set `disp_valid` bits. A presentation made while `disp_ready` is low changes nothing.
- R3: At most one load and one store are offered per cycle. An offered operation is removed at the next clock edge and is never offered again.
- R4: A load is eligible when both address operands (source index 0 and 1) are ready. Among eligible loads, the one with the oldest age is offered, even if older non-eligible loads are waiting.
- R5: A load is never offered while any store older than it is still in the queue.
- R6: Only the oldest store in the queue may be offered. A younger store waits even when its operands are ready.
- R7: A store is offered once its two address operands are ready, whatever the state of its data operand (source index 2). `st_iss_data_rdy` gives that data operand's ready state.
- R8: A broadcast whose tag matches an operand tag marks that operand ready at the clock edge. An operation waiting only on that operand can be offered from the following cycle, not in the broadcast cycle. An operation dispatched in the same cycle as a matching broadcast captures it.
- R9: A flush removes every entry strictly younger than `flush_age` and keeps the rest. In the flush cycle nothing is offered and no dispatch is accepted.
- R10: Ages compare modulo 2^AGE_W. Age a is older than age b when (b - a) mod 2^AGE_W lies in 1 .. 2^(AGE_W-1)-1. Within one dispatch group, slot 0 is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | DISP_W | Per-slot dispatch valid |
| disp_is_store | input | DISP_W | 1 = store, 0 = load |
| disp_age | input | DISP_W x AGE_W | Program-order age stamp per slot |
| disp_id | input | DISP_W x ID_W | Operation identifier returned at issue |
| disp_src_tag | input | DISP_W x 3 x TAG_W | Operand tags (0,1 address, 2 store data) |
| disp_src_rdy | input | DISP_W x 3 | Operand already-ready flags |
| disp_ready | output | 1 | Enough free entries for the presented group |
| wk_valid | input | WK_N | Result broadcast valid per port |
| wk_tag | input | WK_N x TAG_W | Result broadcast tag per port |
| flush_valid | input | 1 | Flush request |
| flush_age | input | AGE_W | Entries younger than this are removed |
| ld_iss_valid | output | 1 | A load is offered this cycle |
| ld_iss_id | output | ID_W | Identifier of the offered load |
| st_iss_valid | output | 1 | A store is offered this cycle |
| st_iss_id | output | ID_W | Identifier of the offered store |
| st_iss_data_rdy | output | 1 | Data operand of the offered store is ready |

## Verification
The assertions assume that every age live in the queue is unique and that all live ages span less than half the age range. Under that assumption, "older" is a consistent order and an age seen in two consecutive cycles names the same operation. The stimulus hands out ages from a running counter, one per accepted operation, and stops dispatching whenever the distance from the oldest waiting entry to the next age exceeds 100. Periodic drain phases broadcast every tag so that stuck entries leave. Flush boundaries are always taken from an age that is currently in the queue.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Operand slots of every queued operation.
  localparam int NSRC   = 3;
  localparam int SRC_A  = 0;   // address base
  localparam int SRC_B  = 1;   // address offset
  localparam int SRC_D  = 2;   // store data

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;

  // True when stamp a precedes stamp b in a w-bit wrapping age space.
  function automatic logic age_before(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] d;
    d = (a - b) & ((32'd1 << w) - 32'd1);
    return (d != 32'd0) && d[w-1];
  endfunction

endpackage

// File: rtl/lsq_alloc.sv
module lsq_alloc #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]             occ,
  output logic [CNT_W-1:0]             free_cnt,
  output logic [DISP_W-1:0][IDX_W-1:0] slot_idx
);

  // Lists the lowest-numbered free entries, one per dispatch lane.
  always_comb begin
    int k;
    k        = 0;
    free_cnt = '0;
    slot_idx = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (!occ[e]) begin
        free_cnt = free_cnt + 1'b1;
        if (k < DISP_W) slot_idx[k] = IDX_W'(e);
        k++;
      end
    end
  end

endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AGE_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][AGE_W-1:0] ages,
  output logic                        found,
  output logic [IDX_W-1:0]            idx,
  output logic [AGE_W-1:0]            age
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    age   = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (cand[e] && (!found || age_before(32'(ages[e]), 32'(age), AGE_W))) begin
        found = 1'b1;
        idx   = IDX_W'(e);
        age   = ages[e];
      end
    end
  end

endmodule

// File: rtl/lsq_issue_queue.sv
module lsq_issue_queue
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 3,
  parameter int WK_N   = 2,
  parameter int TAG_W  = 5,
  parameter int AGE_W  = 8,
  parameter int ID_W   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [DISP_W-1:0]                      disp_valid,
  input  logic [DISP_W-1:0]                      disp_is_store,
  input  logic [DISP_W-1:0][AGE_W-1:0]           disp_age,
  input  logic [DISP_W-1:0][ID_W-1:0]            disp_id,
  input  logic [DISP_W-1:0][NSRC-1:0][TAG_W-1:0] disp_src_tag,
  input  logic [DISP_W-1:0][NSRC-1:0]            disp_src_rdy,
  output logic                                   disp_ready,
  input  logic [WK_N-1:0]                        wk_valid,
  input  logic [WK_N-1:0][TAG_W-1:0]             wk_tag,
  input  logic                                   flush_valid,
  input  logic [AGE_W-1:0]                       flush_age,
  output logic                                   ld_iss_valid,
  output logic [ID_W-1:0]                        ld_iss_id,
  output logic                                   st_iss_valid,
  output logic [ID_W-1:0]                        st_iss_id,
  output logic                                   st_iss_data_rdy
);

  // Entry state
  logic [DEPTH-1:0]                      ent_v;
  logic [DEPTH-1:0]                      ent_st;
  logic [DEPTH-1:0][AGE_W-1:0]           ent_age;
  logic [DEPTH-1:0][ID_W-1:0]            ent_id;
  logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0] ent_tag;
  logic [DEPTH-1:0][NSRC-1:0]            ent_rdy;

  // Named internal events
  logic [DEPTH-1:0]             addr_rdy, st_cand, ld_cand, kill;
  logic                         st_head_valid, ld_found;
  logic [IDX_W-1:0]             st_head_idx, ld_idx;
  logic [AGE_W-1:0]             st_head_age, ld_iss_age, st_iss_age;
  logic [CNT_W-1:0]             free_cnt, n_disp, occ_cnt;
  logic [DISP_W-1:0][IDX_W-1:0] free_slot, disp_slot;
  logic                         disp_fire;

  function automatic logic wake_hit(input logic [TAG_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < WK_N; k++) h = h | (wk_valid[k] && (wk_tag[k] == t));
    return h;
  endfunction

  lsq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) alloc_i (
    .occ      (ent_v),
    .free_cnt (free_cnt),
    .slot_idx (free_slot)
  );

  // Lane i takes the free entry whose rank equals the count of valid lanes below i.
  always_comb begin
    int r;
    r         = 0;
    disp_slot = '0;
    for (int i = 0; i < DISP_W; i++) begin
      disp_slot[i] = free_slot[r];
      if (disp_valid[i]) r++;
    end
    n_disp = CNT_W'(r);
  end

  assign disp_ready = (free_cnt >= n_disp);
  assign disp_fire  = disp_ready && !flush_valid;
  assign occ_cnt    = CNT_W'($countones(ent_v));

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_elig
      assign addr_rdy[e] = ent_rdy[e][SRC_A] && ent_rdy[e][SRC_B];
      assign st_cand[e]  = ent_v[e] && (ent_st[e] == OP_STORE);
      assign ld_cand[e]  = ent_v[e] && (ent_st[e] == OP_LOAD) && addr_rdy[e] &&
                           (!st_head_valid ||
                            age_before(32'(ent_age[e]), 32'(st_head_age), AGE_W));
      assign kill[e]     = (ld_iss_valid && (ld_idx == IDX_W'(e))) ||
                           (st_iss_valid && (st_head_idx == IDX_W'(e))) ||
                           (flush_valid &&
                            age_before(32'(flush_age), 32'(ent_age[e]), AGE_W));
    end
  endgenerate

  // Oldest store overall: the only one allowed to leave.
  lsq_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) st_pick_i (
    .cand  (st_cand),
    .ages  (ent_age),
    .found (st_head_valid),
    .idx   (st_head_idx),
    .age   (st_head_age)
  );

  // Oldest ready load that has no older store ahead of it.
  lsq_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) ld_pick_i (
    .cand  (ld_cand),
    .ages  (ent_age),
    .found (ld_found),
    .idx   (ld_idx),
    .age   (ld_iss_age)
  );

  assign ld_iss_valid    = ld_found && !flush_valid;
  assign ld_iss_id       = ent_id[ld_idx];
  assign st_iss_valid    = st_head_valid && addr_rdy[st_head_idx] && !flush_valid;
  assign st_iss_id       = ent_id[st_head_idx];
  assign st_iss_data_rdy = ent_rdy[st_head_idx][SRC_D];
  assign st_iss_age      = st_head_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        if (ent_v[e] && kill[e]) ent_v[e] <= 1'b0;
      for (int i = 0; i < DISP_W; i++)
        if (disp_fire && disp_valid[i]) ent_v[disp_slot[i]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++)
      if (ent_v[e])
        for (int s = 0; s < NSRC; s++)
          if (wake_hit(ent_tag[e][s])) ent_rdy[e][s] <= 1'b1;
    for (int i = 0; i < DISP_W; i++) begin
      if (disp_fire && disp_valid[i]) begin
        ent_st[disp_slot[i]]  <= disp_is_store[i];
        ent_age[disp_slot[i]] <= disp_age[i];
        ent_id[disp_slot[i]]  <= disp_id[i];
        ent_tag[disp_slot[i]] <= disp_src_tag[i];
        for (int s = 0; s < NSRC; s++)
          ent_rdy[disp_slot[i]][s] <= disp_src_rdy[i][s] || wake_hit(disp_src_tag[i][s]);
      end
    end
  end

endmodule

// File: rtl/lsq_issue_queue_chk.sv
module lsq_issue_queue_chk
  import lsq_pkg::*;
#(
  parameter int AGE_W = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_ready,
  input logic             flush_valid,
  input logic             ld_iss_valid,
  input logic [AGE_W-1:0] ld_iss_age,
  input logic             st_iss_valid,
  input logic [AGE_W-1:0] st_iss_age,
  input logic             st_head_valid,
  input logic [AGE_W-1:0] st_head_age,
  input logic [CNT_W-1:0] occ_cnt
);

  assert_no_grow_when_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> occ_cnt <= $past(occ_cnt));

  assert_load_leaves_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_iss_valid |=> !(ld_iss_valid && ld_iss_age == $past(ld_iss_age)));

  assert_store_leaves_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_iss_valid |=> !(st_iss_valid && st_iss_age == $past(st_iss_age)));

  assert_load_behind_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_iss_valid && st_head_valid) |-> age_before(32'(ld_iss_age), 32'(st_head_age), AGE_W));

  assert_stores_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_iss_valid && $past(st_iss_valid) && !$past(flush_valid)) |->
      age_before(32'($past(st_iss_age)), 32'(st_iss_age), AGE_W));

  assert_flush_no_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> occ_cnt <= $past(occ_cnt));

endmodule

bind lsq_issue_queue lsq_issue_queue_chk #(.AGE_W(AGE_W), .CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .disp_ready    (disp_ready),
  .flush_valid   (flush_valid),
  .ld_iss_valid  (ld_iss_valid),
  .ld_iss_age    (ld_iss_age),
  .st_iss_valid  (st_iss_valid),
  .st_iss_age    (st_iss_age),
  .st_head_valid (st_head_valid),
  .st_head_age   (st_head_age),
  .occ_cnt       (occ_cnt)
);

// File: tb/lsq_issue_queue_tb_top.sv
module lsq_issue_queue_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]            disp_valid, disp_is_store;
  logic [2:0][7:0]       disp_age, disp_id;
  logic [2:0][2:0][4:0]  disp_src_tag;
  logic [2:0][2:0]       disp_src_rdy;
  logic                  disp_ready;
  logic [1:0]            wk_valid;
  logic [1:0][4:0]       wk_tag;
  logic                  flush_valid;
  logic [7:0]            flush_age;
  logic                  ld_iss_valid, st_iss_valid, st_iss_data_rdy;
  logic [7:0]            ld_iss_id, st_iss_id;

  lsq_issue_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_is_store(disp_is_store), .disp_age(disp_age),
    .disp_id(disp_id), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .disp_ready(disp_ready), .wk_valid(wk_valid), .wk_tag(wk_tag),
    .flush_valid(flush_valid), .flush_age(flush_age),
    .ld_iss_valid(ld_iss_valid), .ld_iss_id(ld_iss_id),
    .st_iss_valid(st_iss_valid), .st_iss_id(st_iss_id),
    .st_iss_data_rdy(st_iss_data_rdy)
  );

  // Bench model: operations kept in program order.
  typedef struct packed {
    logic            st;
    logic [7:0]      age;
    logic [7:0]      id;
    logic [2:0][4:0] tag;
    logic [2:0]      rdy;
  } ment_t;

  ment_t      mq[$];
  int         n_chk = 0, n_bad = 0;
  logic [7:0] na = 8'd0;
  bit         m_acc, m_ld_v, m_st_v, m_st_d;
  logic [7:0] m_ld_id, m_st_id;
  int         m_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic bit younger(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return (d != 8'd0) && (d < 8'd128);
  endfunction

  function automatic bit woken(input logic [4:0] t);
    return (wk_valid[0] && wk_tag[0] == t) || (wk_valid[1] && wk_tag[1] == t);
  endfunction

  task automatic idle();
    disp_valid = '0; disp_is_store = '0; disp_age = '0; disp_id = '0;
    disp_src_tag = '0; disp_src_rdy = '0;
    wk_valid = '0; wk_tag = '0; flush_valid = 1'b0; flush_age = '0;
  endtask

  task automatic set_op(input int s, input bit st, input logic [7:0] age,
                        input logic [4:0] t0, input logic [4:0] t1, input logic [4:0] t2,
                        input logic [2:0] rdy);
    disp_valid[s] = 1'b1; disp_is_store[s] = st; disp_age[s] = age; disp_id[s] = age;
    disp_src_tag[s][0] = t0; disp_src_tag[s][1] = t1; disp_src_tag[s][2] = t2;
    disp_src_rdy[s] = rdy;
  endtask

  task automatic wake(input logic [4:0] a, input logic [4:0] b);
    wk_valid = 2'b11; wk_tag[0] = a; wk_tag[1] = b;
  endtask

  // Settle, predict from the model, compare.
  task automatic look();
    bit blocked;
    #1;
    m_n = 0;
    for (int i = 0; i < 3; i++) if (disp_valid[i]) m_n++;
    m_acc  = (mq.size() + m_n <= 16);
    m_ld_v = 0; m_st_v = 0; m_st_d = 0; m_ld_id = 0; m_st_id = 0;
    blocked = 0;
    foreach (mq[j]) begin
      if (mq[j].st) begin
        if (!m_st_v && !blocked) begin
          m_st_v = mq[j].rdy[0] & mq[j].rdy[1];
          m_st_id = mq[j].id; m_st_d = mq[j].rdy[2];
        end
        blocked = 1;
      end else if (!blocked && !m_ld_v && mq[j].rdy[0] && mq[j].rdy[1]) begin
        m_ld_v = 1; m_ld_id = mq[j].id;
      end
    end
    if (flush_valid) begin m_ld_v = 0; m_st_v = 0; end
    check(disp_ready == m_acc, "R2 dispatch ready", disp_ready, m_acc);
    check(ld_iss_valid == m_ld_v, "R4 load offered", ld_iss_valid, m_ld_v);
    if (m_ld_v) check(ld_iss_id == m_ld_id, "R4 load choice", ld_iss_id, m_ld_id);
    check(st_iss_valid == m_st_v, "R6 store offered", st_iss_valid, m_st_v);
    if (m_st_v) begin
      check(st_iss_id == m_st_id, "R6 store choice", st_iss_id, m_st_id);
      check(st_iss_data_rdy == m_st_d, "R7 store data flag", st_iss_data_rdy, m_st_d);
    end
  endtask

  // Clock edge, then apply the same edge to the model.
  task automatic tick();
    ment_t nq[$];
    @(posedge clk);
    foreach (mq[j]) begin
      bit gone;
      gone = (m_ld_v && mq[j].id == m_ld_id) || (m_st_v && mq[j].id == m_st_id) ||
             (flush_valid && younger(mq[j].age, flush_age));
      if (!gone) begin
        ment_t m;
        m = mq[j];
        for (int s = 0; s < 3; s++) if (woken(m.tag[s])) m.rdy[s] = 1'b1;
        nq.push_back(m);
      end
    end
    if (m_acc && !flush_valid)
      for (int i = 0; i < 3; i++) if (disp_valid[i]) begin
        ment_t m;
        m.st = disp_is_store[i]; m.age = disp_age[i]; m.id = disp_id[i];
        m.tag = disp_src_tag[i]; m.rdy = disp_src_rdy[i];
        for (int s = 0; s < 3; s++) if (woken(m.tag[s])) m.rdy[s] = 1'b1;
        nq.push_back(m);
      end
    mq = nq;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int c = 0; c < 300 && mq.size() > 0; c++) begin
      idle();
      wake(5'((2 * c) % 32), 5'((2 * c + 1) % 32));
      look(); tick();
    end
    idle();
    check(mq.size() == 0, "R3 drain empties", mq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    look();
    check(ld_iss_valid == 0, "R1 no load", ld_iss_valid, 0);
    check(st_iss_valid == 0, "R1 no store", st_iss_valid, 0);
    check(disp_ready == 1, "R1 ready", disp_ready, 1);
    tick();

    // R7/R5: store with missing data leaves; younger load waits behind it
    set_op(0, 1, 8'd0, 5'd1, 5'd2, 5'd3, 3'b011);
    set_op(1, 0, 8'd1, 5'd4, 5'd5, 5'd6, 3'b011);
    look(); tick(); idle(); look();
    check(st_iss_valid == 1 && st_iss_id == 0, "R7 store without data", st_iss_id, 0);
    check(st_iss_data_rdy == 0, "R7 data flag low", st_iss_data_rdy, 0);
    check(ld_iss_valid == 0, "R5 load held by older store", ld_iss_valid, 0);
    tick(); look();
    check(ld_iss_valid == 1 && ld_iss_id == 1, "R5 load after store", ld_iss_id, 1);
    tick();

    // R6/R8: younger ready store waits for older one; wakeup takes one cycle
    set_op(0, 1, 8'd2, 5'd7, 5'd8, 5'd0, 3'b100);
    set_op(1, 1, 8'd3, 5'd1, 5'd1, 5'd1, 3'b111);
    look(); tick(); idle(); look();
    check(st_iss_valid == 0, "R6 younger store waits", st_iss_valid, 0);
    tick(); wake(5'd7, 5'd8); look();
    check(st_iss_valid == 0, "R8 no same-cycle wakeup", st_iss_valid, 0);
    tick(); idle(); look();
    check(st_iss_valid == 1 && st_iss_id == 2, "R8 eligible next cycle", st_iss_id, 2);
    tick(); look();
    check(st_iss_valid == 1 && st_iss_id == 3, "R6 order kept", st_iss_id, 3);
    tick();

    // R4: ready younger load passes a waiting older load
    set_op(0, 0, 8'd4, 5'd9, 5'd9, 5'd0, 3'b000);
    set_op(1, 0, 8'd5, 5'd1, 5'd1, 5'd0, 3'b011);
    look(); tick(); idle(); wake(5'd9, 5'd9); look();
    check(ld_iss_valid == 1 && ld_iss_id == 5, "R4 younger load first", ld_iss_id, 5);
    tick(); idle(); look();
    check(ld_iss_valid == 1 && ld_iss_id == 4, "R4 older load later", ld_iss_id, 4);
    tick();
    na = 8'd6;

    // R2: capacity and stall
    for (int c = 0; c < 5; c++) begin
      for (int s = 0; s < 3; s++) set_op(s, 0, na + 8'(s), 5'd12, 5'd12, 5'd0, 3'b000);
      look(); tick(); idle(); na = na + 8'd3;
    end
    for (int s = 0; s < 3; s++) set_op(s, 0, na + 8'(s), 5'd12, 5'd12, 5'd0, 3'b000);
    look();
    check(disp_ready == 0, "R2 stall with 1 free", disp_ready, 0);
    tick(); idle();
    set_op(0, 0, na, 5'd12, 5'd12, 5'd0, 3'b000);
    look();
    check(disp_ready == 1, "R2 single fits", disp_ready, 1);
    tick(); idle(); na = na + 8'd1;
    set_op(0, 0, na, 5'd12, 5'd12, 5'd0, 3'b011);
    look();
    check(disp_ready == 0, "R2 full", disp_ready, 0);
    tick(); idle();
    check(mq.size() == 16, "R2 occupancy", mq.size(), 16);
    drain();

    // R9: flush keeps the boundary entry, drops younger, blocks issue and dispatch
    set_op(0, 1, na, 5'd1, 5'd1, 5'd1, 3'b111);
    set_op(1, 1, na + 8'd1, 5'd13, 5'd13, 5'd0, 3'b000);
    set_op(2, 1, na + 8'd2, 5'd13, 5'd13, 5'd0, 3'b000);
    look(); tick(); idle();
    flush_valid = 1'b1; flush_age = na;
    set_op(0, 0, na + 8'd3, 5'd1, 5'd1, 5'd0, 3'b011);
    look();
    check(st_iss_valid == 0, "R9 no issue during flush", st_iss_valid, 0);
    tick(); idle(); look();
    check(st_iss_valid == 1 && st_iss_id == na, "R9 boundary kept", st_iss_id, na);
    check(ld_iss_valid == 0, "R9 dispatch in flush ignored", ld_iss_valid, 0);
    tick(); wake(5'd13, 5'd13); look(); tick(); idle(); look();
    check(st_iss_valid == 0, "R9 younger removed", st_iss_valid, 0);
    tick();
    na = na + 8'd3;

    // R10: ordering across the age wrap
    set_op(0, 0, 8'd254, 5'd14, 5'd14, 5'd0, 3'b000);
    set_op(1, 0, 8'd2, 5'd14, 5'd14, 5'd0, 3'b000);
    look(); tick(); idle(); wake(5'd14, 5'd14); look(); tick(); idle(); look();
    check(ld_iss_valid == 1 && ld_iss_id == 254, "R10 pre-wrap age older", ld_iss_id, 254);
    tick(); look();
    check(ld_iss_valid == 1 && ld_iss_id == 2, "R10 post-wrap age next", ld_iss_id, 2);
    tick();
    na = 8'd3;

    // Random phases, each followed by a drain
    for (int ph = 0; ph < 40; ph++) begin
      for (int c = 0; c < 80; c++) begin
        int k;
        bit cap;
        idle();
        cap = (mq.size() > 0) && (8'(na - mq[0].age) > 8'd100);
        k = 0;
        for (int s = 0; s < 3; s++)
          if (!cap && ($urandom % 3 == 0)) begin
            set_op(s, 1'($urandom), na + 8'(k), 5'($urandom), 5'($urandom),
                   5'($urandom), 3'($urandom));
            k++;
          end
        for (int p = 0; p < 2; p++) begin
          wk_valid[p] = 1'($urandom);
          wk_tag[p]   = 5'($urandom);
        end
        if (mq.size() > 0 && ($urandom % 25 == 0)) begin
          flush_valid = 1'b1;
          flush_age   = mq[$urandom % mq.size()].age;
        end
        look();
        if (m_acc && !flush_valid) na = na + 8'(k);
        tick();
      end
      drain();
    end

    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

endmodule